// File: doc/BRIEF.md
# Bit-Serial Real-Time-Clock Register Access Engine

This block is a host-side master for a real-time-clock device that exposes its registers over a four-wire serial bus. The bus has an active-low chip select, an active-low write strobe, an active-low read strobe and one shared bidirectional data line. Every bit moves in its own bit cycle, framed by chip select and timed by a single strobe. Consecutive bit cycles are separated by an idle gap.

A host raises `req_valid` for one clock with a 4-bit register address, a direction flag and 8 bits of write data. The engine always sends the address nibble first. For a write it then sends eight data bits. For a read it runs eight read bit cycles and assembles the returned byte. Addresses in the command range carry no data phase, so the transaction ends after the nibble. Strobe and gap lengths are set by `CLK_PER_US`, the number of system clocks in one microsecond. The data line is exposed as an output value, an output enable and an input, so the pad ring can build the tri-state buffer.

Top module: `rtcbus_master`

## Requirements
- R1: During and right after reset, `bus_cs_n`, `bus_wr_n` and `bus_rd_n` are high, `bus_dq_o` is high with `bus_dq_oe` high, and `busy` and `done` are low.
- R2: Every transaction starts with the `ADDR_W` (4) address bits, least significant bit first. Each address bit is carried by its own write-strobe bit cycle.
- R3: In a write bit cycle, `bus_dq_o` takes the bit value before `bus_cs_n` falls. Chip select and `bus_wr_n` are then low together for exactly `CLK_PER_US` clocks, and `bus_dq_o` stays stable while `bus_wr_n` is low. `bus_wr_n` rises while chip select is still low, and chip select rises afterwards.
- R4: In a read bit cycle, `bus_dq_oe` is low. Chip select and `bus_rd_n` are low for exactly 2*`CLK_PER_US` clocks. The line is sampled once, at the end of the first `CLK_PER_US` clocks. `bus_rd_n` rises before chip select.
- R5: A register write sends 8 data bits after the address, least significant bit first.
- R6: A register read runs 8 read bit cycles after the address. The first bit received becomes `rd_data[0]` and the last becomes `rd_data[7]`. `rd_data` holds the byte from the cycle in which `done` pulses.
- R7: An address at or above `CMD_FIRST` (default 14, that is 0xE and 0xF) is a command. Its transaction ends after the address nibble, whatever `req_write` says. `done` still pulses, and `rd_data` keeps its previous value.
- R8: Between consecutive bit cycles of a transaction, `bus_cs_n` stays high for at least `CLK_PER_US` clocks.
- R9: A request is accepted when `req_valid` is high at a clock edge while `busy` is low. `busy` is high from the next cycle until the gap of the last bit cycle has ended. A `req_valid` that arrives while `busy` is high is ignored.
- R10: At most one of `bus_wr_n` and `bus_rd_n` is low in any cycle, and `bus_dq_oe` is low whenever `bus_rd_n` is low.
- R11: `done` is a one-cycle pulse. It is high in the first cycle in which `busy` is low again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_write | input | 1 | 1 = register write, 0 = register read |
| req_addr | input | ADDR_W | Register or command address |
| req_wdata | input | DATA_W | Byte to write |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| rd_data | output | DATA_W | Byte assembled by the last read |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_dq_o | output | 1 | Value driven on the data line |
| bus_dq_oe | output | 1 | Data line output enable |
| bus_dq_i | input | 1 | Value seen on the data line |

## Verification
Two events can land on the same clock edge. A new request can arrive in the cycle where `done` pulses and `busy` falls. A spurious `req_valid` can also overlap the last bit cycle of a running transaction. The bench provokes the first case by issuing each request on the first edge at which `busy` is seen low. It provokes the second by holding `req_valid` high with a different address and data across a whole transaction. A behavioural device model on the pins decodes every transaction and feeds it into a scoreboard. Any ignored request that leaks onto the bus shows up there as an extra or misordered transaction, and a later read of the targeted register shows that its content did not change.

// File: rtl/rtcbus_pkg.sv
package rtcbus_pkg;

  // Phases of one bit cycle on the serial bus.
  typedef enum logic [2:0] {
    PH_IDLE,      // no bit cycle, chip select high
    PH_SETUP,     // data line set up, strobes still high
    PH_STROBE,    // chip select and strobe low, first period
    PH_HOLD,      // read only: second period after sampling
    PH_UNSTROBE,  // strobe high again, chip select still low
    PH_GAP        // chip select high, spacing to the next bit
  } bit_phase_e;

  // Index of the final bit cycle of a transaction.
  function automatic int unsigned last_bit_index(input logic is_cmd,
                                                 input int unsigned aw,
                                                 input int unsigned dw);
    return is_cmd ? (aw - 1) : (aw + dw - 1);
  endfunction

  // Serial byte assembly: a new bit enters at the top.
  function automatic logic [7:0] shift_in_top(input logic [7:0] acc,
                                              input logic b);
    return {b, acc[7:1]};
  endfunction

endpackage

// File: rtl/rtcbus_timer.sv
module rtcbus_timer #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (load)           cnt <= load_val;
    else if (cnt != '0)      cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/rtcbus_phy.sv
module rtcbus_phy
  import rtcbus_pkg::*;
#(
  parameter int unsigned CLK_PER_US = 125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic rd_bit,
  input  logic wr_val,
  input  logic dq_i,
  output logic cs_n,
  output logic wr_n,
  output logic rd_n,
  output logic dq_o,
  output logic dq_oe,
  output logic phy_idle,
  output logic smp_stb,
  output logic smp_val,
  output logic cyc_done
);
  localparam int unsigned CW = $clog2(CLK_PER_US + 1);
  localparam logic [CW-1:0] PERIOD_LOAD = CW'(CLK_PER_US - 1);

  bit_phase_e ph, ph_nxt;
  logic       tmr_load, tmr_exp;
  logic       cyc_rd, cyc_val;

  rtcbus_timer #(.CW(CW)) tmr_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (PERIOD_LOAD),
    .expired  (tmr_exp)
  );

  always_comb begin
    ph_nxt   = ph;
    tmr_load = 1'b0;
    smp_stb  = 1'b0;
    cyc_done = 1'b0;
    unique case (ph)
      PH_IDLE:     if (start) ph_nxt = PH_SETUP;
      PH_SETUP: begin
        ph_nxt   = PH_STROBE;
        tmr_load = 1'b1;
      end
      PH_STROBE: if (tmr_exp) begin
        if (cyc_rd) begin
          ph_nxt   = PH_HOLD;
          tmr_load = 1'b1;
          smp_stb  = 1'b1;
        end else begin
          ph_nxt = PH_UNSTROBE;
        end
      end
      PH_HOLD:     if (tmr_exp) ph_nxt = PH_UNSTROBE;
      PH_UNSTROBE: begin
        ph_nxt   = PH_GAP;
        tmr_load = 1'b1;
      end
      PH_GAP: if (tmr_exp) begin
        ph_nxt   = PH_IDLE;
        cyc_done = 1'b1;
      end
      default:     ph_nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph <= PH_IDLE;
    else        ph <= ph_nxt;
  end

  // Cycle kind and bit value are held for the whole cycle and the idle after it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_rd  <= 1'b0;
      cyc_val <= 1'b1;
    end else if (ph == PH_IDLE && start) begin
      cyc_rd  <= rd_bit;
      cyc_val <= rd_bit ? 1'b1 : wr_val;
    end
  end

  assign cs_n     = !(ph == PH_STROBE || ph == PH_HOLD || ph == PH_UNSTROBE);
  assign wr_n     = !(ph == PH_STROBE && !cyc_rd);
  assign rd_n     = !((ph == PH_STROBE || ph == PH_HOLD) && cyc_rd);
  assign dq_o     = cyc_val;
  assign dq_oe    = !cyc_rd;
  assign phy_idle = (ph == PH_IDLE);
  assign smp_val  = dq_i;
endmodule

// File: rtl/rtcbus_seq.sv
module rtcbus_seq
  import rtcbus_pkg::*;
#(
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned CMD_FIRST = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              phy_idle,
  input  logic              cyc_done,
  input  logic              smp_stb,
  input  logic              smp_val,
  output logic              start,
  output logic              rd_bit,
  output logic              wr_val,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rd_data
);
  localparam int unsigned NBITS = ADDR_W + DATA_W;
  localparam int unsigned IW    = $clog2(NBITS);
  localparam logic [IW-1:0] LAST_CMD = IW'(last_bit_index(1'b1, ADDR_W, DATA_W));
  localparam logic [IW-1:0] LAST_RW  = IW'(last_bit_index(1'b0, ADDR_W, DATA_W));

  logic [IW-1:0]     idx;
  logic [ADDR_W-1:0] addr_sh;
  logic [DATA_W-1:0] data_sh, acc;
  logic              r_write, r_cmd, launch;
  logic              in_addr, accept, last_bit;

  function automatic logic [DATA_W-1:0] push_top(input logic [DATA_W-1:0] a,
                                                 input logic b);
    return {b, a[DATA_W-1:1]};
  endfunction

  assign accept   = req_valid && !busy;
  assign in_addr  = (idx < IW'(ADDR_W));
  assign last_bit = (idx == (r_cmd ? LAST_CMD : LAST_RW));
  assign rd_bit   = !in_addr && !r_write;
  assign wr_val   = in_addr ? addr_sh[0] : data_sh[0];
  assign start    = launch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      launch  <= 1'b0;
      idx     <= '0;
      addr_sh <= '0;
      data_sh <= '0;
      acc     <= '0;
      r_write <= 1'b0;
      r_cmd   <= 1'b0;
      rd_data <= '0;
    end else begin
      done <= 1'b0;
      if (launch && phy_idle) launch <= 1'b0;
      if (accept) begin
        busy    <= 1'b1;
        launch  <= 1'b1;
        idx     <= '0;
        addr_sh <= req_addr;
        data_sh <= req_wdata;
        acc     <= '0;
        r_write <= req_write;
        r_cmd   <= (req_addr >= ADDR_W'(CMD_FIRST));
      end else if (busy) begin
        if (smp_stb) acc <= push_top(acc, smp_val);
        if (cyc_done) begin
          if (in_addr) addr_sh <= addr_sh >> 1;
          else         data_sh <= data_sh >> 1;
          if (last_bit) begin
            busy <= 1'b0;
            done <= 1'b1;
            if (!r_write && !r_cmd) rd_data <= acc;
          end else begin
            idx    <= idx + 1'b1;
            launch <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/rtcbus_master.sv
module rtcbus_master #(
  parameter int unsigned CLK_PER_US = 125,
  parameter int unsigned ADDR_W     = 4,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned CMD_FIRST  = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic              bus_cs_n,
  output logic              bus_wr_n,
  output logic              bus_rd_n,
  output logic              bus_dq_o,
  output logic              bus_dq_oe,
  input  logic              bus_dq_i
);
  // Internal events, named for the checker.
  logic start, rd_bit, wr_val, phy_idle;
  logic smp_stb, smp_val, cyc_done;

  rtcbus_seq #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .CMD_FIRST (CMD_FIRST)
  ) seq_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .phy_idle  (phy_idle),
    .cyc_done  (cyc_done),
    .smp_stb   (smp_stb),
    .smp_val   (smp_val),
    .start     (start),
    .rd_bit    (rd_bit),
    .wr_val    (wr_val),
    .busy      (busy),
    .done      (done),
    .rd_data   (rd_data)
  );

  rtcbus_phy #(.CLK_PER_US(CLK_PER_US)) phy_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .rd_bit   (rd_bit),
    .wr_val   (wr_val),
    .dq_i     (bus_dq_i),
    .cs_n     (bus_cs_n),
    .wr_n     (bus_wr_n),
    .rd_n     (bus_rd_n),
    .dq_o     (bus_dq_o),
    .dq_oe    (bus_dq_oe),
    .phy_idle (phy_idle),
    .smp_stb  (smp_stb),
    .smp_val  (smp_val),
    .cyc_done (cyc_done)
  );
endmodule

// File: rtl/rtcbus_master_chk.sv
module rtcbus_master_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic wr_n,
  input logic rd_n,
  input logic dq_o,
  input logic dq_oe,
  input logic busy,
  input logic done,
  input logic smp_stb
);
  p_single_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(!wr_n && !rd_n));

  p_oe_off_in_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !dq_oe);

  p_cs_frames_wr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> !cs_n);

  p_wr_rises_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_n) |-> !cs_n);

  p_dq_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_n && $past(!wr_n)) |-> $stable(dq_o));

  p_rd_rises_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_n) |-> !cs_n);

  p_sample_in_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    smp_stb |-> (!rd_n && !cs_n));

  p_strobe_needs_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> busy);

  p_done_ends_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind rtcbus_master rtcbus_master_chk chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .cs_n    (bus_cs_n),
  .wr_n    (bus_wr_n),
  .rd_n    (bus_rd_n),
  .dq_o    (bus_dq_o),
  .dq_oe   (bus_dq_oe),
  .busy    (busy),
  .done    (done),
  .smp_stb (smp_stb)
);

// File: tb/rtcbus_master_tb_top.sv
module rtcbus_master_tb_top;
  localparam int unsigned T = 6;

  typedef struct packed {
    logic [1:0] kind;   // 0 read, 1 write, 2 command
    logic [3:0] addr;
    logic [7:0] data;
  } txn_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [3:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic busy, done, cs_n, wr_n, rd_n, dq_o, dq_oe, dq_i;
  logic [7:0] rd_data;

  int n_vec = 0, n_bad = 0, cycles = 0;
  txn_t exp_q[$], bus_q[$];
  logic [7:0] mirror [16];
  logic [7:0] mem [16];
  logic [7:0] hold_rd = 8'h00;

  // device model state
  int mcnt = 0;
  logic [3:0] maddr = '0;
  logic [7:0] mdata = '0;
  logic prev_wr = 1'b1, prev_rd = 1'b1, prev_cs = 1'b1, prev_done = 1'b0;
  int wcnt = 0, rcnt = 0, ccnt = 0;
  int wmin = 1000, wmax = 0, rmin = 1000, rmax = 0, gmin = 1000;
  bit gap_arm = 0;
  int ovl = 0, oe_bad = 0;

  always #4 clk = ~clk;

  rtcbus_master #(.CLK_PER_US(T)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
    .rd_data(rd_data), .bus_cs_n(cs_n), .bus_wr_n(wr_n), .bus_rd_n(rd_n),
    .bus_dq_o(dq_o), .bus_dq_oe(dq_oe), .bus_dq_i(dq_i)
  );

  assign dq_i = (!rd_n && mcnt >= 4 && mcnt < 12) ? mem[maddr][3'(mcnt - 4)] : 1'b1;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  // device model, timing monitor and scoreboard compare
  always @(negedge clk) begin
    txn_t t, e;
    if (rst_n) begin
      if (!wr_n && !rd_n) ovl++;
      if (!rd_n && dq_oe) oe_bad++;
      if (prev_wr == 1'b0 && wr_n == 1'b1) begin
        if (mcnt < 4) begin
          maddr[2'(mcnt)] = dq_o;
          mcnt++;
          if (mcnt == 4 && maddr >= 4'hE) begin
            t = '{2'd2, maddr, 8'h00}; bus_q.push_back(t); mcnt = 0;
          end
        end else begin
          mdata[3'(mcnt - 4)] = dq_o;
          mcnt++;
          if (mcnt == 12) begin
            mem[maddr] = mdata;
            t = '{2'd1, maddr, mdata}; bus_q.push_back(t); mcnt = 0;
          end
        end
      end
      if (prev_rd == 1'b0 && rd_n == 1'b1) begin
        mcnt++;
        if (mcnt == 12) begin
          t = '{2'd0, maddr, mem[maddr]}; bus_q.push_back(t); mcnt = 0;
        end
      end
      if (!wr_n) wcnt++;
      else if (wcnt > 0) begin
        if (wcnt < wmin) wmin = wcnt;
        if (wcnt > wmax) wmax = wcnt;
        wcnt = 0;
      end
      if (!rd_n) rcnt++;
      else if (rcnt > 0) begin
        if (rcnt < rmin) rmin = rcnt;
        if (rcnt > rmax) rmax = rcnt;
        rcnt = 0;
      end
      if (cs_n) begin
        ccnt++;
        if (!prev_cs && busy) gap_arm = 1;
      end else begin
        if (prev_cs && gap_arm && ccnt < gmin) gmin = ccnt;
        gap_arm = 0;
        ccnt = 0;
      end
      if (done) begin
        check(!busy, "R11 busy low with done", int'(busy), 0);
        check(!prev_done, "R11 done single cycle", int'(prev_done), 0);
        if (exp_q.size() == 0 || bus_q.size() == 0) begin
          check(0, "R9 scoreboard item present", bus_q.size(), exp_q.size());
        end else begin
          e = exp_q.pop_front();
          t = bus_q.pop_front();
          check(t.kind == e.kind, "R7 transaction kind", int'(t.kind), int'(e.kind));
          check(t.addr == e.addr, "R2 address LSB first", int'(t.addr), int'(e.addr));
          if (e.kind == 2'd1)
            check(t.data == e.data, "R5 write data LSB first", int'(t.data), int'(e.data));
          if (e.kind == 2'd0)
            check(rd_data == e.data, "R6 read data assembly", int'(rd_data), int'(e.data));
          if (e.kind == 2'd2)
            check(rd_data == e.data, "R7 rd_data unchanged by command", int'(rd_data), int'(e.data));
        end
      end
    end
    prev_wr = wr_n; prev_rd = rd_n; prev_cs = cs_n; prev_done = done;
  end

  task automatic issue(input logic wr, input logic [3:0] a, input logic [7:0] d);
    txn_t e;
    do @(negedge clk); while (busy);
    if (a >= 4'hE) e = '{2'd2, a, hold_rd};
    else if (wr) begin e = '{2'd1, a, d}; mirror[a] = d; end
    else begin e = '{2'd0, a, mirror[a]}; hold_rd = mirror[a]; end
    exp_q.push_back(e);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    check(busy == 1'b1, "R9 busy after accept", int'(busy), 1);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin
      mem[i] = 8'(i * 37 + 5);
      mirror[i] = 8'(i * 37 + 5);
    end
    repeat (3) @(negedge clk);
    check(cs_n && wr_n && rd_n, "R1 strobes high in reset", {cs_n, wr_n, rd_n}, 7);
    rst_n = 1'b1;
    @(negedge clk);
    check(cs_n && wr_n && rd_n && dq_o && dq_oe, "R1 bus idle after reset",
          {cs_n, wr_n, rd_n, dq_o, dq_oe}, 31);
    check(!busy && !done, "R1 busy and done low", {busy, done}, 0);

    issue(1'b1, 4'h0, 8'h33);
    issue(1'b0, 4'h0, 8'h00);
    issue(1'b1, 4'h3, 8'hA5);
    issue(1'b0, 4'h3, 8'h00);
    issue(1'b1, 4'h7, 8'h01);
    issue(1'b1, 4'h8, 8'h80);
    issue(1'b0, 4'h7, 8'h00);
    issue(1'b0, 4'h8, 8'h00);
    issue(1'b0, 4'h9, 8'h00);
    issue(1'b1, 4'hE, 8'hFF);   // R7 command, write flag set
    issue(1'b0, 4'hF, 8'h00);   // R7 command, read flag set
    issue(1'b1, 4'hD, 8'h6C);
    issue(1'b0, 4'hD, 8'h00);
    // R9: request held high across a busy transaction must be ignored
    issue(1'b1, 4'h2, 8'h5A);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 4'h5; req_wdata = 8'h77;
    while (busy) @(negedge clk);
    req_valid = 1'b0;
    issue(1'b0, 4'h5, 8'h00);   // R9 register 5 keeps its initial content
    issue(1'b0, 4'h2, 8'h00);
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);

    check(exp_q.size() == 0 && bus_q.size() == 0, "R9 scoreboard drained",
          exp_q.size() + bus_q.size(), 0);
    check(wmin == T && wmax == T, "R3 write strobe width", wmax, T);
    check(rmin == 2 * T && rmax == 2 * T, "R4 read strobe width", rmax, 2 * T);
    check(gmin >= T && gmin < 1000, "R8 gap between bit cycles", gmin, T);
    check(ovl == 0, "R10 single strobe", ovl, 0);
    check(oe_bad == 0, "R10 output enable off in read", oe_bad, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule